// File: doc/BRIEF.md
# Codirectional 64 kbit/s receiver with ping-pong time-slot output

This block takes a dual-rail, active-low codirectional line signal at 64 kbit/s and turns it into whole octets. Each octet is then sent as a short serial burst inside one time slot of a 2.048 Mbit/s PCM stream. The line side runs on a 128 kHz clock recovered from the received signal, giving two samples per data bit. The output side runs on the local 2.048 MHz clock and is gated by a time-slot envelope. Two envelope inputs are hard-wired, and a select pin chooses between them.

Octet alignment comes from the polarity violation that the far end places in every octet. Two octet registers swap roles at each octet boundary: one fills from the continuous line stream while the other is available to the bursty output. The hand-over crosses the clock domains as a toggle that is resynchronised in the output domain. The two rates are never locked together. A slot that finds no new octet repeats the previous one. When several octets complete between two slots, only the newest is sent, so whole octets are dropped and never parts of one.

Top module: `codir_rx`

## Requirements
- R1: A mark is present when `line_pos_n` or `line_neg_n` is low. A low on `line_pos_n` is a positive mark and a low on `line_neg_n` alone is a negative mark. Both rails high is a space.
- R2: Every data bit occupies two consecutive `clk_line` samples. The bit decodes as 1 when both samples are marks or both are spaces, and as 0 when exactly one of them is a mark.
- R3: A mark with the same polarity as the previous mark is a violation. A violation that does not fall on the second sample of the last bit of an octet realigns the receiver: the next sample becomes the first half of bit 1, and the partial octet is discarded. No octet is stored before the first violation. Once aligned, an octet completes every `OCTET_W` bits.
- R4: The first received bit of an octet is its most significant bit, and it is the first bit emitted in a slot.
- R5: A completed octet becomes available to the output side and is sent in the next slot that starts after it has crossed the clock domains. The line side then fills the other register.
- R6: While the selected envelope is high at a rising `clk_pcm` edge, `pcm_out` shows one octet bit after that edge, for `OCTET_W` consecutive edges starting from the slot's first edge. After an edge with the envelope low, `pcm_out` is 0.
- R7: With `ts_pick` = 1 the envelope is `ts_a`. With `ts_pick` = 0 it is `ts_b`. The unselected input has no effect on `pcm_out`.
- R8: A slot that starts with no newly available octet repeats the last octet sent.
- R9: When more than one octet became available since the previous slot, only the most recent is sent and the older ones are dropped whole.
- R10: Until the first octet is available, every slot bit equals `IDLE_BIT` (default 1).
- R11: While `rst_n` is low, `pcm_out` is 0 and no octet is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_line | input | 1 | Recovered line clock, two samples per data bit |
| line_pos_n | input | 1 | Positive-mark rail, active low |
| line_neg_n | input | 1 | Negative-mark rail, active low |
| clk_pcm | input | 1 | Local PCM bit clock |
| ts_a | input | 1 | Time-slot envelope, first hard-wired position |
| ts_b | input | 1 | Time-slot envelope, second hard-wired position |
| ts_pick | input | 1 | Envelope select: 1 picks `ts_a`, 0 picks `ts_b` |
| pcm_out | output | 1 | Serial PCM data, octet bits inside the slot, 0 outside |

## Verification
The bench builds the block with `OCTET_W` = 8 and `SYNC_STAGES` = 3. The three-stage synchroniser is the longer hand-over path, so the bench's margin between an octet completing and a slot starting still covers the worst crossing latency. With octets of eight bits and a line clock about twelve times slower than the PCM clock, slot spacing alone reaches three regimes within a few thousand cycles: every octet sent twice (repeat), several octets between slots (deletion), and near-equal rates. A deliberately misplaced violation in mid-stream shows that the partial octet is discarded and that alignment comes back on the next full octet.

// File: rtl/codir_rx_pkg.sv
`timescale 1ns/1ps
package codir_rx_pkg;
   typedef enum logic {HALF_FIRST = 1'b0, HALF_SECOND = 1'b1} half_e;
   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_OCTET_W     = 2;
endpackage

// File: rtl/codir_rx_linedec.sv
`timescale 1ns/1ps
module codir_rx_linedec
   import codir_rx_pkg::*;
#(
   parameter int OCTET_W = 8,
   localparam int IDX_W = $clog2(OCTET_W)
) (
   input  logic             clk_line,
   input  logic             rst_n,
   input  logic             line_pos_n,
   input  logic             line_neg_n,
   output logic             bit_stb,
   output logic             bit_val,
   output logic [IDX_W-1:0] bit_idx,
   output logic             octet_done,
   output logic             realign
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OCTET_W - 1);

   logic             mark_now, pol_now;
   logic             last_pol, seen_mark, aligned, first_smp;
   half_e            half;
   logic [IDX_W-1:0] bitcnt;
   logic             viol, in_place;

   // R1: rails merged; both low counts as a positive mark
   assign mark_now = ~line_pos_n | ~line_neg_n;
   assign pol_now  = line_pos_n & ~line_neg_n;
   assign viol     = mark_now & seen_mark & (pol_now == last_pol);
   assign in_place = aligned & (half == HALF_SECOND) & (bitcnt == LAST_IDX);

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n) begin
         last_pol   <= 1'b0;
         seen_mark  <= 1'b0;
         aligned    <= 1'b0;
         first_smp  <= 1'b0;
         half       <= HALF_FIRST;
         bitcnt     <= '0;
         bit_stb    <= 1'b0;
         bit_val    <= 1'b0;
         bit_idx    <= '0;
         octet_done <= 1'b0;
         realign    <= 1'b0;
      end else begin
         bit_stb    <= 1'b0;
         octet_done <= 1'b0;
         realign    <= 1'b0;
         if (mark_now) begin
            last_pol  <= pol_now;
            seen_mark <= 1'b1;
         end
         if (viol && !in_place) begin
            aligned <= 1'b1;
            half    <= HALF_FIRST;
            bitcnt  <= '0;
            realign <= 1'b1;
         end else if (aligned) begin
            if (half == HALF_FIRST) begin
               first_smp <= mark_now;
               half      <= HALF_SECOND;
            end else begin
               half    <= HALF_FIRST;
               bit_stb <= 1'b1;
               bit_val <= (first_smp == mark_now);   // R2
               bit_idx <= bitcnt;
               if (bitcnt == LAST_IDX) begin
                  bitcnt     <= '0;
                  octet_done <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/codir_rx_banks.sv
`timescale 1ns/1ps
module codir_rx_banks #(
   parameter int OCTET_W = 8,
   localparam int IDX_W = $clog2(OCTET_W)
) (
   input  logic                   clk_line,
   input  logic                   rst_n,
   input  logic                   bit_stb,
   input  logic                   bit_val,
   input  logic [IDX_W-1:0]       bit_idx,
   input  logic                   octet_done,
   output logic [1:0][OCTET_W-1:0] banks,
   output logic                   done_sel,
   output logic                   swap_tgl
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OCTET_W - 1);

   logic wr_sel;

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n) begin
         banks    <= '0;
         wr_sel   <= 1'b0;
         done_sel <= 1'b0;
         swap_tgl <= 1'b0;
      end else begin
         if (bit_stb) banks[wr_sel][LAST_IDX - bit_idx] <= bit_val;   // R4: MSB first
         if (octet_done) begin
            wr_sel   <= ~wr_sel;
            done_sel <= wr_sel;
            swap_tgl <= ~swap_tgl;
         end
      end
   end
endmodule

// File: rtl/codir_rx_sync.sv
`timescale 1ns/1ps
module codir_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/codir_rx_slot.sv
`timescale 1ns/1ps
module codir_rx_slot #(
   parameter int   OCTET_W  = 8,
   parameter logic IDLE_BIT = 1'b1,
   localparam int IDX_W = $clog2(OCTET_W)
) (
   input  logic                    clk_pcm,
   input  logic                    rst_n,
   input  logic                    ts_a,
   input  logic                    ts_b,
   input  logic                    ts_pick,
   input  logic                    tgl_sync,
   input  logic                    done_sel,
   input  logic [1:0][OCTET_W-1:0] banks,
   output logic                    pcm_out,
   output logic                    have_octet,
   output logic                    fresh
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OCTET_W - 1);

   logic             env, tgl_d, arrive, new_sel, rd_sel, pick_sel;
   logic [IDX_W-1:0] oidx;

   assign env      = ts_pick ? ts_a : ts_b;               // R7
   assign arrive   = tgl_sync ^ tgl_d;
   assign pick_sel = (oidx == '0 && fresh) ? new_sel : rd_sel;

   always_ff @(posedge clk_pcm or negedge rst_n) begin
      if (!rst_n) begin
         tgl_d      <= 1'b0;
         fresh      <= 1'b0;
         new_sel    <= 1'b0;
         rd_sel     <= 1'b0;
         have_octet <= 1'b0;
         oidx       <= '0;
         pcm_out    <= 1'b0;
      end else begin
         tgl_d <= tgl_sync;
         if (env) begin
            if (oidx == '0 && fresh) begin                // R8/R9: newest only
               rd_sel     <= new_sel;
               have_octet <= 1'b1;
               fresh      <= 1'b0;
            end
            pcm_out <= (have_octet || (oidx == '0 && fresh))
                       ? banks[pick_sel][LAST_IDX - oidx] : IDLE_BIT;
            oidx    <= (oidx == LAST_IDX) ? '0 : oidx + 1'b1;
         end else begin
            pcm_out <= 1'b0;
            oidx    <= '0;
         end
         if (arrive) begin
            fresh   <= 1'b1;
            new_sel <= done_sel;
         end
      end
   end
endmodule

// File: rtl/codir_rx.sv
`timescale 1ns/1ps
module codir_rx
   import codir_rx_pkg::*;
#(
   parameter int   OCTET_W     = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_BIT    = 1'b1
) (
   input  logic rst_n,
   input  logic clk_line,
   input  logic line_pos_n,
   input  logic line_neg_n,
   input  logic clk_pcm,
   input  logic ts_a,
   input  logic ts_b,
   input  logic ts_pick,
   output logic pcm_out
);
   localparam int IDX_W = $clog2(OCTET_W);

   if (OCTET_W < MIN_OCTET_W) begin : g_bad_width
      $error("codir_rx: OCTET_W below minimum");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("codir_rx: SYNC_STAGES below minimum");
   end

   logic                    dec_bit_stb, dec_bit_val, dec_done, dec_realign;
   logic [IDX_W-1:0]        dec_bit_idx;
   logic [1:0][OCTET_W-1:0] bank_q;
   logic                    done_sel, rx_tgl, rx_tgl_s;
   logic                    slot_valid, slot_fresh;

   codir_rx_linedec #(.OCTET_W(OCTET_W)) u_dec (
      .clk_line   (clk_line),
      .rst_n      (rst_n),
      .line_pos_n (line_pos_n),
      .line_neg_n (line_neg_n),
      .bit_stb    (dec_bit_stb),
      .bit_val    (dec_bit_val),
      .bit_idx    (dec_bit_idx),
      .octet_done (dec_done),
      .realign    (dec_realign)
   );

   codir_rx_banks #(.OCTET_W(OCTET_W)) u_banks (
      .clk_line   (clk_line),
      .rst_n      (rst_n),
      .bit_stb    (dec_bit_stb),
      .bit_val    (dec_bit_val),
      .bit_idx    (dec_bit_idx),
      .octet_done (dec_done),
      .banks      (bank_q),
      .done_sel   (done_sel),
      .swap_tgl   (rx_tgl)
   );

   codir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk_pcm),
      .rst_n   (rst_n),
      .d_async (rx_tgl),
      .q_sync  (rx_tgl_s)
   );

   codir_rx_slot #(.OCTET_W(OCTET_W), .IDLE_BIT(IDLE_BIT)) u_slot (
      .clk_pcm    (clk_pcm),
      .rst_n      (rst_n),
      .ts_a       (ts_a),
      .ts_b       (ts_b),
      .ts_pick    (ts_pick),
      .tgl_sync   (rx_tgl_s),
      .done_sel   (done_sel),
      .banks      (bank_q),
      .pcm_out    (pcm_out),
      .have_octet (slot_valid),
      .fresh      (slot_fresh)
   );
endmodule

// File: rtl/codir_rx_chk.sv
`timescale 1ns/1ps
module codir_rx_chk #(
   parameter int   OCTET_W  = 8,
   parameter logic IDLE_BIT = 1'b1
) (
   input logic clk_line,
   input logic clk_pcm,
   input logic rst_n,
   input logic ts_a,
   input logic ts_b,
   input logic ts_pick,
   input logic pcm_out,
   input logic dec_bit_stb,
   input logic dec_done,
   input logic dec_realign,
   input logic rx_tgl,
   input logic slot_valid,
   input logic slot_fresh
);
   localparam int CW = $clog2(OCTET_W) + 1;

   logic          env;
   logic [CW-1:0] bits_seen;

   assign env = ts_pick ? ts_a : ts_b;

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n)                      bits_seen <= '0;
      else if (dec_done || dec_realign) bits_seen <= '0;
      else if (dec_bit_stb)            bits_seen <= bits_seen + 1'b1;
   end

   p_octet_len_r3: assert property (@(posedge clk_line) disable iff (!rst_n)
      dec_done |-> (dec_bit_stb && bits_seen == CW'(OCTET_W - 1)));

   p_swap_on_done_r5: assert property (@(posedge clk_line) disable iff (!rst_n)
      dec_done |=> (rx_tgl != $past(rx_tgl)));

   p_hold_no_done_r5: assert property (@(posedge clk_line) disable iff (!rst_n)
      !dec_done |=> (rx_tgl == $past(rx_tgl)));

   p_zero_outside_r6: assert property (@(posedge clk_pcm) disable iff (!rst_n)
      !env |=> !pcm_out);

   p_idle_fill_r10: assert property (@(posedge clk_pcm) disable iff (!rst_n)
      (env && !slot_valid && !slot_fresh) |=> (pcm_out == IDLE_BIT));

   p_valid_sticky_r8: assert property (@(posedge clk_pcm) disable iff (!rst_n)
      slot_valid |=> slot_valid);
endmodule

bind codir_rx codir_rx_chk #(.OCTET_W(OCTET_W), .IDLE_BIT(IDLE_BIT)) i_chk (
   .clk_line    (clk_line),
   .clk_pcm     (clk_pcm),
   .rst_n       (rst_n),
   .ts_a        (ts_a),
   .ts_b        (ts_b),
   .ts_pick     (ts_pick),
   .pcm_out     (pcm_out),
   .dec_bit_stb (dec_bit_stb),
   .dec_done    (dec_done),
   .dec_realign (dec_realign),
   .rx_tgl      (rx_tgl),
   .slot_valid  (slot_valid),
   .slot_fresh  (slot_fresh)
);

// File: tb/test_codir_rx.sv
`timescale 1ns/1ps
module test_codir_rx;
   localparam int W = 8;
   localparam int SETTLE = 24;   // sys cycles before a completed octet counts
   localparam int GUARD  = 30;   // bench keeps slot starts this far from completions

   logic rst_n = 1'b0;
   logic clk_pcm = 1'b0;
   logic clk_line = 1'b0;
   logic line_pos_n = 1'b1, line_neg_n = 1'b1;
   logic ts_a = 1'b0, ts_b = 1'b1, ts_pick = 1'b1;
   logic pcm_out;

   codir_rx #(.OCTET_W(W), .SYNC_STAGES(3), .IDLE_BIT(1'b1)) i_codir_rx (
      .rst_n(rst_n), .clk_line(clk_line), .line_pos_n(line_pos_n),
      .line_neg_n(line_neg_n), .clk_pcm(clk_pcm), .ts_a(ts_a), .ts_b(ts_b),
      .ts_pick(ts_pick), .pcm_out(pcm_out)
   );

   always #4 clk_pcm = ~clk_pcm;
   initial begin
      #53 clk_line = 1'b1;
      forever begin #50 clk_line = 1'b0; #50 clk_line = 1'b1; end
   end

   int n_cmp = 0, n_bad = 0, cyc = 0, pat = 0, n_pushed = 0, last_stamp = 0;
   bit have_stamp = 0, line_done = 0, started = 0, finished = 0, last_pol = 0;
   logic [W-1:0] q_data[$];
   int           q_stamp[$];

   // reference model
   logic [W-1:0] m_cur;
   bit           m_have = 0, exp_out = 0;
   int           m_idx = 0, n_new = 0;
   string        tag = "R11";

   always @(posedge clk_pcm) begin
      cyc++;
      started = 1;
      if (!rst_n) begin
         exp_out = 0; m_idx = 0; m_have = 0; tag = "R11";
      end else if (ts_pick ? ts_a : ts_b) begin
         if (m_idx == 0) begin
            n_new = 0;
            while (q_data.size() > 0 && q_stamp[0] <= cyc - SETTLE) begin
               m_cur = q_data.pop_front();
               void'(q_stamp.pop_front());
               n_new++;
               m_have = 1;
            end
            tag = !m_have ? "R10" : (n_new == 0) ? "R8" : (n_new > 1) ? "R9" : "R5";
            tag = {tag, " R6 (R1 R2 R3 R4)", ts_pick ? "" : " R7"};
         end
         exp_out = m_have ? m_cur[W-1-m_idx] : 1'b1;
         m_idx = (m_idx == W-1) ? 0 : m_idx + 1;
      end else begin
         exp_out = 0; m_idx = 0; tag = "R6 R7";
      end
   end

   always @(negedge clk_pcm) begin
      if (started && !finished) begin
         n_cmp++;
         if (pcm_out !== exp_out) begin
            n_bad++;
            $display("FAIL %s: pcm_out=%b expected %b at cycle %0d", tag, pcm_out, exp_out, cyc);
         end
      end
   end

   // line stimulus
   task automatic put_half(input bit m, input bit p);
      @(negedge clk_line);
      line_pos_n = !(m && !p);
      line_neg_n = !(m && p);
      if (m) last_pol = p;
   endtask

   task automatic send_bit(input bit v, input bit viol);
      bit p;
      pat++;
      if (viol) begin
         if (v) begin p = !last_pol; put_half(1, p); put_half(1, p); end
         else   begin put_half(0, 0); put_half(1, last_pol); end
      end else if (v) begin
         if (pat % 2 == 1) begin put_half(1, !last_pol); put_half(1, !last_pol); end
         else              begin put_half(0, 0); put_half(0, 0); end
      end else begin
         if (pat % 2 == 1) begin put_half(1, !last_pol); put_half(0, 0); end
         else              begin put_half(0, 0); put_half(1, !last_pol); end
      end
   endtask

   task automatic send_octet(input logic [W-1:0] d, input bit rec);
      for (int i = W-1; i >= 0; i--) send_bit(d[i], i == 0);
      if (rec) begin
         @(posedge clk_line); #1;
         q_data.push_back(d);
         q_stamp.push_back(cyc);
         last_stamp = cyc;
         have_stamp = 1;
         n_pushed++;
      end
   endtask

   task automatic line_thread();
      send_octet(8'h3C, 0);                     // R3: first violation only aligns
      for (int k = 0; k < 12; k++)
         send_octet((k == 3) ? 8'h00 : (k == 4) ? 8'hFF : 8'((k * 37 + 11) & 8'hFF), 1);
      send_bit(1, 0); send_bit(0, 0); send_bit(1, 1);   // R3: misplaced violation
      for (int k = 0; k < 8; k++) send_octet(8'((k * 91 + 5) & 8'hFF), 1);
      line_done = 1;
   endtask

   // slot stimulus
   task automatic do_slot(input bit use_a);
      @(negedge clk_pcm);
      while (have_stamp && (cyc - last_stamp) < GUARD) @(negedge clk_pcm);
      ts_pick = use_a; ts_a = use_a; ts_b = !use_a;
      repeat (W) @(negedge clk_pcm);
      ts_a = !use_a; ts_b = use_a;              // unselected input held high (R7)
   endtask

   task automatic slot_thread();
      int gap, n = 0;
      repeat (10) @(negedge clk_pcm);
      do_slot(1);                               // R10 before any octet
      while (!line_done) begin
         gap = (n_pushed < 6) ? 90 : (n_pushed < 12) ? 470 : 210;
         repeat (gap) @(negedge clk_pcm);
         do_slot(n % 3 != 0);
         n++;
      end
      repeat (60) @(negedge clk_pcm);
      do_slot(1);
      repeat (20) @(negedge clk_pcm);
      do_slot(0);
   endtask

   initial begin
      repeat (5) @(negedge clk_pcm);
      rst_n = 1'b1;
      fork
         line_thread();
         slot_thread();
      join
      repeat (4) @(negedge clk_pcm);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1600000;
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run incomplete, expected completion before cycle %0d (actual %0d)", 200000, cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule